// File: doc/BRIEF.md
# VCI Command Flit Serializer

This block converts command packets arriving on a VCI-style initiator port into a stream of 40-bit flits for the command side of a mesh network-on-chip. Every command begins with an address flit, then a header flit that carries the source identifier, command code, contiguity bits, packet length and the thread and packet identifiers. Write-type commands then send one data flit for each VCI word. The most significant bit of every flit is the end-of-packet marker.

The block classifies commands by the VCI CMD code. Plain reads and locked reads each use a single VCI flit and become two network flits. Writes, store-conditionals and compare-and-swap commands carry 1 to 16 VCI flits and become that number plus two. Address and source-identifier inputs narrower than the network fields are left-aligned and padded with zeros. The first VCI flit of a packet is held in a register while the address and header flits go out. The rest of a write burst flows straight through, paced by the downstream ready signal.

Top module: `vci_cmd_flit_serializer`

## Requirements
- R1: The first flit of every command has bit 39 (end of packet) at 0, the network address bits 39..2 in flit bits 38..1, and bit 0 (broadcast) at 0.
- R2: A command whose CMD bit 0 is 1 (01 read, 11 locked read) produces exactly two flits. The second is {1, SRCID[13:0], CMD[1:0], CGT[1:0], PLEN[7:0], TRDID[3:0], PKTID[3:0], BE[3:0], 0}.
- R3: A command whose CMD bit 0 is 0 (10 write, 00 store-conditional or compare-and-swap) with N VCI flits produces N+2 flits. The second is {0, SRCID[13:0], CMD[1:0], CGT[1:0], PLEN[7:0], TRDID[3:0], PKTID[3:0], 00000}.
- R4: Each data flit of a write-type command is {EOP, 000, BE[3:0], WDATA[31:0]} taken from the matching VCI flit in order. End of packet is set only on the flit that comes from the VCI flit carrying EOP.
- R5: An ADDR_W-bit input address is placed at the top of a 40-bit network address, with zeros below it.
- R6: An SRCID_W-bit source identifier is placed at the top of the 14-bit SRCID field, with zeros below it.
- R7: Once the first VCI flit of a packet is accepted, in_ready stays low until the header flit has been accepted downstream.
- R8: While out_valid is high and out_ready is low, on the next cycle out_valid stays high and out_flit is unchanged.
- R9: While rst_n is low, out_valid is 0. A few cycles after rst_n rises, in_ready is 1 and out_valid is 0.
- R10: In the cycle after a flit with end of packet is accepted, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | VCI command flit valid |
| in_ready | output | 1 | VCI command flit accepted when high with in_valid |
| in_addr | input | ADDR_W | Byte address |
| in_cmd | input | 2 | Command code |
| in_cgt | input | 2 | Contiguity and constant-address bits |
| in_plen | input | 8 | Packet length in bytes |
| in_trdid | input | 4 | Thread identifier |
| in_pktid | input | 4 | Packet identifier |
| in_srcid | input | SRCID_W | Initiator identifier |
| in_be | input | 4 | Byte enables |
| in_wdata | input | 32 | Write data |
| in_eop | input | 1 | Last VCI flit of the packet |
| out_valid | output | 1 | Network flit valid |
| out_ready | input | 1 | Network accepts the flit |
| out_flit | output | 40 | Network flit, bit 39 is end of packet |

## Verification
The bench targets read-type and write-type commands that share CMD bit 1, so a design that split on the wrong bit would send a header with the wrong end-of-packet bit and drop or invent data flits. It runs single-flit and sixteen-flit write bursts to catch a missing or extra data flit. It also covers long downstream stalls during the address, header and first data flits, where a design that let go of its captured flit would change out_flit or accept a new VCI flit too early. A second instance, with a 32-bit address and a 10-bit SRCID, catches right-aligned or truncated fields.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  localparam int FLIT_W  = 40;
  localparam int NADDR_W = 40;
  localparam int NSRC_W  = 14;
  localparam int CMD_W   = 2;
  localparam int CGT_W   = 2;
  localparam int PLEN_W  = 8;
  localparam int ID_W    = 4;
  localparam int BE_W    = 4;
  localparam int DATA_W  = 32;

  typedef struct packed {
    logic [NADDR_W-1:0] addr;
    logic [NSRC_W-1:0]  srcid;
    logic [CMD_W-1:0]   cmd;
    logic [CGT_W-1:0]   cgt;
    logic [PLEN_W-1:0]  plen;
    logic [ID_W-1:0]    trdid;
    logic [ID_W-1:0]    pktid;
    logic [BE_W-1:0]    be;
    logic [DATA_W-1:0]  wdata;
    logic               eop;
  } vfs_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_HDR    = 3'd2,
    ST_WFIRST = 3'd3,
    ST_BODY   = 3'd4
  } vfs_state_e;

  // Bit 0 of the command code separates read-type (01, 11) from write-type (10, 00)
  function automatic logic cmd_is_read(input logic [CMD_W-1:0] cmd);
    return cmd[0];
  endfunction

endpackage

// File: rtl/vfs_rst_sync.sv
module vfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/vfs_left_align.sv
module vfs_left_align #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 40
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (IN_W == OUT_W) begin : g_same
      assign dout = din;
    end else begin : g_pad
      localparam int PAD_W = OUT_W - IN_W;
      assign dout = {din, {PAD_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/vfs_capture.sv
module vfs_capture
  import vfs_pkg::*;
(
  input  logic     clk,
  input  logic     en,
  input  vfs_cmd_t d,
  output vfs_cmd_t q
);
  vfs_cmd_t q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end
endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       in_valid,
  input  logic       in_eop,
  input  logic       out_ready,
  input  logic       cap_read,
  input  logic       cap_eop,
  output vfs_state_e state,
  output logic       in_ready,
  output logic       out_valid,
  output logic       cap_en
);
  vfs_state_e state_next;

  always_comb begin
    state_next = state;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    cap_en     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        in_ready = run;
        cap_en   = run & in_valid;
        if (run && in_valid) state_next = ST_ADDR;
      end
      ST_ADDR: begin
        out_valid = 1'b1;
        if (out_ready) state_next = ST_HDR;
      end
      ST_HDR: begin
        out_valid = 1'b1;
        if (out_ready) state_next = cap_read ? ST_IDLE : ST_WFIRST;
      end
      ST_WFIRST: begin
        out_valid = 1'b1;
        if (out_ready) state_next = cap_eop ? ST_IDLE : ST_BODY;
      end
      ST_BODY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        if (in_valid && out_ready && in_eop) state_next = ST_IDLE;
      end
      default: state_next = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_next;
  end
endmodule

// File: rtl/vfs_flit_fmt.sv
module vfs_flit_fmt
  import vfs_pkg::*;
(
  input  vfs_state_e          state,
  input  vfs_cmd_t            cap,
  input  logic [BE_W-1:0]     live_be,
  input  logic [DATA_W-1:0]   live_wdata,
  input  logic                live_eop,
  output logic [FLIT_W-1:0]   flit
);
  logic [FLIT_W-1:0] addr_flit;
  logic [FLIT_W-1:0] rd_hdr;
  logic [FLIT_W-1:0] wr_hdr;
  logic [FLIT_W-1:0] cap_data;
  logic [FLIT_W-1:0] live_data;

  always_comb begin
    addr_flit = {1'b0, cap.addr[NADDR_W-1:2], 1'b0};
    rd_hdr    = {1'b1, cap.srcid, cap.cmd, cap.cgt, cap.plen,
                 cap.trdid, cap.pktid, cap.be, 1'b0};
    wr_hdr    = {1'b0, cap.srcid, cap.cmd, cap.cgt, cap.plen,
                 cap.trdid, cap.pktid, 5'b00000};
    cap_data  = {cap.eop, 3'b000, cap.be, cap.wdata};
    live_data = {live_eop, 3'b000, live_be, live_wdata};
  end

  always_comb begin
    unique case (state)
      ST_ADDR:   flit = addr_flit;
      ST_HDR:    flit = cmd_is_read(cap.cmd) ? rd_hdr : wr_hdr;
      ST_WFIRST: flit = cap_data;
      ST_BODY:   flit = live_data;
      default:   flit = '0;
    endcase
  end
endmodule

// File: rtl/vci_cmd_flit_serializer.sv
module vci_cmd_flit_serializer
  import vfs_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int SRCID_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [1:0]         in_cmd,
  input  logic [1:0]         in_cgt,
  input  logic [7:0]         in_plen,
  input  logic [3:0]         in_trdid,
  input  logic [3:0]         in_pktid,
  input  logic [SRCID_W-1:0] in_srcid,
  input  logic [3:0]         in_be,
  input  logic [31:0]        in_wdata,
  input  logic               in_eop,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [39:0]        out_flit
);
  logic [NADDR_W-1:0] addr_al;
  logic [NSRC_W-1:0]  srcid_al;
  vfs_cmd_t           live;
  vfs_cmd_t           cap;
  vfs_state_e         state;
  logic               cap_en;
  logic               run;

  vfs_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  vfs_left_align #(.IN_W(ADDR_W), .OUT_W(NADDR_W)) u_al_addr (
    .din  (in_addr),
    .dout (addr_al)
  );

  vfs_left_align #(.IN_W(SRCID_W), .OUT_W(NSRC_W)) u_al_src (
    .din  (in_srcid),
    .dout (srcid_al)
  );

  always_comb begin
    live.addr  = addr_al;
    live.srcid = srcid_al;
    live.cmd   = in_cmd;
    live.cgt   = in_cgt;
    live.plen  = in_plen;
    live.trdid = in_trdid;
    live.pktid = in_pktid;
    live.be    = in_be;
    live.wdata = in_wdata;
    live.eop   = in_eop;
  end

  vfs_capture u_cap (
    .clk (clk),
    .en  (cap_en),
    .d   (live),
    .q   (cap)
  );

  vfs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .out_ready (out_ready),
    .cap_read  (cmd_is_read(cap.cmd)),
    .cap_eop   (cap.eop),
    .state     (state),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .cap_en    (cap_en)
  );

  vfs_flit_fmt u_fmt (
    .state      (state),
    .cap        (cap),
    .live_be    (in_be),
    .live_wdata (in_wdata),
    .live_eop   (in_eop),
    .flit       (out_flit)
  );
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [39:0] out_flit
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

  p_addr_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> (out_valid && !out_flit[39] && !out_flit[0]));

  p_lock_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> !in_ready);

  p_idle_after_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_flit[39]) |=> (!out_valid && in_ready));

  p_quiet_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind vci_cmd_flit_serializer vfs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit)
);

// File: tb/tb_vci_cmd_flit_serializer.sv
`timescale 1ns/1ps
module tb_vci_cmd_flit_serializer;
  localparam int MAXF = 1024;

  logic clk;
  logic rst_n;
  logic in_valid, out_ready;
  logic [39:0] in_addr;
  logic [1:0]  in_cmd, in_cgt;
  logic [7:0]  in_plen;
  logic [3:0]  in_trdid, in_pktid, in_be;
  logic [13:0] in_srcid;
  logic [31:0] in_wdata;
  logic        in_eop;
  logic        in_ready, out_valid;
  logic [39:0] out_flit;
  logic        n_in_ready, n_out_valid;
  logic [39:0] n_out_flit;

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  vci_cmd_flit_serializer #(.ADDR_W(40), .SRCID_W(14)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_cgt(in_cgt), .in_plen(in_plen),
    .in_trdid(in_trdid), .in_pktid(in_pktid), .in_srcid(in_srcid),
    .in_be(in_be), .in_wdata(in_wdata), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit));

  vci_cmd_flit_serializer #(.ADDR_W(32), .SRCID_W(10)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(n_in_ready),
    .in_addr(in_addr[31:0]), .in_cmd(in_cmd), .in_cgt(in_cgt), .in_plen(in_plen),
    .in_trdid(in_trdid), .in_pktid(in_pktid), .in_srcid(in_srcid[9:0]),
    .in_be(in_be), .in_wdata(in_wdata), .in_eop(in_eop),
    .out_valid(n_out_valid), .out_ready(out_ready), .out_flit(n_out_flit));

  // stimulus store
  logic [39:0] s_addr [MAXF];
  logic [13:0] s_src  [MAXF];
  logic [1:0]  s_cmd  [MAXF];
  logic [1:0]  s_cgt  [MAXF];
  logic [7:0]  s_plen [MAXF];
  logic [3:0]  s_trd  [MAXF];
  logic [3:0]  s_pkt  [MAXF];
  logic [3:0]  s_be   [MAXF];
  logic [31:0] s_dat  [MAXF];
  logic        s_eop  [MAXF];
  int nflits = 0;

  // reference model state
  logic [39:0] q_w [$];
  string       t_w [$];
  logic [39:0] q_n [$];
  string       t_n [$];
  bit   pkt_first = 1;
  int   to_hdr = 0;
  bit   exp_idle = 0;
  bit   prev_stall = 0;
  logic [39:0] prev_w, prev_n;

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [39:0] hdr(input logic [13:0] s, input int i);
    if (s_cmd[i][0])
      return {1'b1, s, s_cmd[i], s_cgt[i], s_plen[i], s_trd[i], s_pkt[i], s_be[i], 1'b0};
    return {1'b0, s, s_cmd[i], s_cgt[i], s_plen[i], s_trd[i], s_pkt[i], 5'b0};
  endfunction

  function automatic logic [39:0] dflit(input int i);
    return {s_eop[i], 3'b000, s_be[i], s_dat[i]};
  endfunction

  task automatic model_in(input int i);
    logic [39:0] na;
    na = {s_addr[i][31:0], 8'h00};
    if (pkt_first) begin
      q_w.push_back({1'b0, s_addr[i][39:2], 1'b0}); t_w.push_back("R1");
      q_n.push_back({1'b0, na[39:2], 1'b0});        t_n.push_back("R5");
      q_w.push_back(hdr(s_src[i], i));
      t_w.push_back(s_cmd[i][0] ? "R2" : "R3");
      q_n.push_back(hdr({s_src[i][9:0], 4'h0}, i)); t_n.push_back("R6");
      to_hdr = 2;
    end
    if (!s_cmd[i][0]) begin
      q_w.push_back(dflit(i)); t_w.push_back("R4");
      q_n.push_back(dflit(i)); t_n.push_back("R4");
    end
    pkt_first = s_eop[i];
  endtask

  initial begin : stimgen
    int n = 0;
    for (int p = 0; p < 36; p++) begin
      int t = p % 6;
      int len;
      logic [39:0] base;
      logic [1:0] c;
      logic [2:0] pk;
      logic [13:0] src;
      logic [1:0] cg;
      logic [3:0] tr;
      base = {$urandom(), $urandom()};
      base[5:0] = 6'd0;
      src = 14'($urandom());
      cg = 2'($urandom());
      tr = 4'($urandom());
      case (t)
        0: begin c = 2'b01; pk = 3'b001; len = 1; end
        1: begin c = 2'b11; pk = 3'b110; len = 1; end
        3: begin c = 2'b00; pk = 3'b111; len = 2; end
        4: begin c = 2'b00; pk = 3'b101; len = 2; end
        default: begin
          c = 2'b10; pk = 3'b100;
          case (p % 4)
            0: len = 1;
            1: len = 16;
            2: len = ((p * 3) % 15) + 1;
            default: len = 4;
          endcase
        end
      endcase
      for (int k = 0; k < len; k++) begin
        s_addr[n] = base + 40'(4 * k);
        s_src[n]  = src;
        s_cmd[n]  = c;
        s_cgt[n]  = cg;
        s_plen[n] = 8'(len * 4);
        s_trd[n]  = tr;
        s_pkt[n]  = {1'($urandom()), pk};
        s_be[n]   = 4'($urandom());
        s_dat[n]  = $urandom();
        s_eop[n]  = (k == len - 1);
        n++;
      end
    end
    nflits = n;
  end

  initial begin : run
    int idx = 0;
    int cyc = 0;
    bit hs_done = 0;
    bit in_hs, out_hs;
    rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0;
    in_addr = '0; in_cmd = '0; in_cgt = '0; in_plen = '0; in_trdid = '0;
    in_pktid = '0; in_srcid = '0; in_be = '0; in_wdata = '0; in_eop = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", 40'(out_valid), 40'd0); // in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", {38'd0, out_valid, in_ready}, 40'd1);
    while ((idx < nflits || q_w.size() != 0) && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (hs_done || !in_valid) begin
        hs_done = 0;
        if (idx < nflits && ($urandom() % 4) != 0) begin
          in_valid = 1'b1;
          in_addr = s_addr[idx]; in_cmd = s_cmd[idx]; in_cgt = s_cgt[idx];
          in_plen = s_plen[idx]; in_trdid = s_trd[idx]; in_pktid = s_pkt[idx];
          in_srcid = s_src[idx]; in_be = s_be[idx]; in_wdata = s_dat[idx];
          in_eop = s_eop[idx];
        end else begin
          in_valid = 1'b0;
        end
      end
      if (idx < 40)       out_ready = 1'b1;
      else if (idx < 140) out_ready = (($urandom() % 3) != 0);
      else                out_ready = (($urandom() % 5) == 0);
      #2;
      // per-cycle checks, just before the rising edge
      check(n_out_valid == out_valid && n_in_ready == in_ready, "R5",
            {38'd0, n_out_valid, n_in_ready}, {38'd0, out_valid, in_ready});
      if (exp_idle) begin
        check(!out_valid && in_ready, "R10", {38'd0, out_valid, in_ready}, 40'd1);
        exp_idle = 0;
      end
      if (to_hdr > 0)
        check(in_ready == 1'b0, "R7", 40'(in_ready), 40'd0);
      if (prev_stall) begin
        check(out_valid && out_flit == prev_w, "R8", out_flit, prev_w);
        check(n_out_valid && n_out_flit == prev_n, "R8", n_out_flit, prev_n);
      end
      in_hs  = in_valid && in_ready;
      out_hs = out_valid && out_ready;
      if (in_hs) begin
        model_in(idx);
        idx++;
        hs_done = 1;
      end
      if (out_hs) begin
        if (q_w.size() == 0) begin
          check(1'b0, "R4", out_flit, 40'd0);
        end else begin
          logic [39:0] ew, en;
          string tw, tn;
          ew = q_w.pop_front(); tw = t_w.pop_front();
          en = q_n.pop_front(); tn = t_n.pop_front();
          check(out_flit == ew, tw, out_flit, ew);
          check(n_out_flit == en, tn, n_out_flit, en);
          if (to_hdr > 0) to_hdr--;
          if (ew[39]) exp_idle = 1;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_w = out_flit;
      prev_n = n_out_flit;
    end
    in_valid = 1'b0;
    if (cyc >= 30000) check(1'b0, "R4", 40'(q_w.size()), 40'd0); // watchdog
    check(idx == nflits && q_w.size() == 0, "R3", 40'(idx), 40'(nflits));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule